// File: doc/BRIEF.md
# Bidirectional Counter with Direction-Dependent Terminal Flag

This block is a synchronous N-bit counter. Its next value comes from one of two paths: an incrementer or a decrementer, each built as a ripple chain of half-cells. A single direction input selects the path. The same direction input also decides what the terminal flag means. When counting up, the flag marks the all-ones value. When counting down, it marks the all-zeros value. A parent controller can therefore use the flag to detect the last step before a wrap in either direction.

Three controls act on the count, in priority order. A synchronous clear forces zero. A parallel load captures a data word. A count enable then advances the value by one step in the selected direction. With none of them active, the count holds. If the direction is tied to up and only the enable and clear are used, the block works as an elapsed-cycle timer.

Top module: `updn_tc_counter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the count becomes zero regardless of the other inputs.
- R2: With `rst_n` high, `clr` high at a rising edge sets the count to zero, whatever `ld` and `en` are.
- R3: With `clr` low and `ld` high at a rising edge, the count takes `ld_val`, whatever `en` and `dir` are.
- R4: With `clr` and `ld` low, `en` high and `dir` = 0 (up), the count increases by one at the edge. All ones wraps to zero.
- R5: With `clr` and `ld` low, `en` high and `dir` = 1 (down), the count decreases by one at the edge. Zero wraps to all ones.
- R6: With `clr`, `ld` and `en` all low, the count keeps its value across the edge.
- R7: While `dir` = 0, `tc` is 1 exactly when the count is all ones. The flag is combinational in the same cycle and does not depend on `en`.
- R8: While `dir` = 1, `tc` is 1 exactly when the count is all zeros. The flag is combinational in the same cycle and does not depend on `en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous clear to zero, highest priority |
| ld | input | 1 | Parallel load strobe |
| ld_val | input | WIDTH | Value captured on load |
| en | input | 1 | Count enable |
| dir | input | 1 | Direction: 0 counts up, 1 counts down |
| count | output | WIDTH | Current count |
| tc | output | 1 | Terminal flag: all ones when up, all zeros when down |

## Verification
The count register is the only state in the block, and it is visible directly on `count`. A wrong value therefore shows up in the cycle right after the edge that produced it. A broken carry or borrow chain appears only for the start values whose low bits are all ones (for increment) or all zeros (for decrement). For that reason every start value is loaded and then stepped in both directions, with the enable both high and low. A fault in the flag selection shows up in the same cycle as the direction change, so the flag is checked before each edge for every value and direction.

// File: rtl/updn_pkg.sv
// Package: shared types for the bidirectional counter.
// Assumes the direction encoding 0 = up, 1 = down.
package updn_pkg;
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;
endpackage

// File: rtl/cnt_step.sv
// Module: cnt_step
// Adds or subtracts one using a ripple chain of half-cells.
// DOWN = 0 gives an incrementer (carry chain).
// DOWN = 1 gives a decrementer (borrow chain).
// Both wrap modulo 2**WIDTH. Purely combinational.
module cnt_step #(
    parameter int WIDTH = 4,
    parameter bit DOWN  = 1'b0
) (
    input  logic [WIDTH-1:0] val_i,
    output logic [WIDTH-1:0] val_o
);
    logic [WIDTH:0] chain;

    assign chain[0] = 1'b1;

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        assign val_o[i] = val_i[i] ^ chain[i];
        if (DOWN) begin : g_borrow
            assign chain[i+1] = ~val_i[i] & chain[i];
        end else begin : g_carry
            assign chain[i+1] = val_i[i] & chain[i];
        end
    end

    // The final carry or borrow is the wrap indicator; it is not needed here.
    logic unused_wrap;
    assign unused_wrap = chain[WIDTH];
endmodule

// File: rtl/cnt_tc_detect.sv
// Module: cnt_tc_detect
// Produces the terminal flag: the AND of all count bits in the up direction,
// and the NOR of all count bits in the down direction.
// Assumes dir uses the package encoding. Purely combinational.
module cnt_tc_detect
    import updn_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] val_i,
    input  dir_e             dir_i,
    output logic             tc_o
);
    logic all_ones;
    logic all_zeros;

    assign all_ones  = &val_i;
    assign all_zeros = ~|val_i;

    // Purpose: pick the detector that matches the counting direction.
    always_comb begin
        case (dir_i)
            DIR_DOWN: tc_o = all_zeros;
            default:  tc_o = all_ones;
        endcase
    end
endmodule

// File: rtl/cnt_next_sel.sv
// Module: cnt_next_sel
// Chooses the next register value by priority:
// clear, then load, then step, else hold.
// The stepped value is selected by direction from the two step units.
module cnt_next_sel
    import updn_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur_i,
    input  logic [WIDTH-1:0] inc_i,
    input  logic [WIDTH-1:0] dec_i,
    input  logic [WIDTH-1:0] ld_val_i,
    input  logic             clr_i,
    input  logic             ld_i,
    input  logic             en_i,
    input  dir_e             dir_i,
    output logic [WIDTH-1:0] nxt_o
);
    logic [WIDTH-1:0] stepped;

    // Purpose: direction mux between the incremented and decremented values.
    always_comb begin
        stepped = (dir_i == DIR_DOWN) ? dec_i : inc_i;
    end

    // Purpose: apply the control priority to form the next value.
    always_comb begin
        if (clr_i)      nxt_o = '0;
        else if (ld_i)  nxt_o = ld_val_i;
        else if (en_i)  nxt_o = stepped;
        else            nxt_o = cur_i;
    end
endmodule

// File: rtl/updn_tc_counter.sv
// Module: updn_tc_counter (top)
// N-bit up/down counter with a synchronous active-low reset, a synchronous
// clear, a parallel load and a count enable. The terminal flag follows the
// direction. Assumes all control inputs are synchronous to clk.
module updn_tc_counter
    import updn_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ld,
    input  logic [WIDTH-1:0] ld_val,
    input  logic             en,
    input  logic             dir,
    output logic [WIDTH-1:0] count,
    output logic             tc
);
    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] cnt_inc;
    logic [WIDTH-1:0] cnt_dec;
    logic [WIDTH-1:0] cnt_nxt;
    dir_e             dir_sel;

    assign dir_sel = dir_e'(dir);

    cnt_step #(.WIDTH(WIDTH), .DOWN(1'b0)) inc_i (
        .val_i (cnt_q),
        .val_o (cnt_inc)
    );

    cnt_step #(.WIDTH(WIDTH), .DOWN(1'b1)) dec_i (
        .val_i (cnt_q),
        .val_o (cnt_dec)
    );

    cnt_next_sel #(.WIDTH(WIDTH)) sel_i (
        .cur_i    (cnt_q),
        .inc_i    (cnt_inc),
        .dec_i    (cnt_dec),
        .ld_val_i (ld_val),
        .clr_i    (clr),
        .ld_i     (ld),
        .en_i     (en),
        .dir_i    (dir_sel),
        .nxt_o    (cnt_nxt)
    );

    cnt_tc_detect #(.WIDTH(WIDTH)) tc_i (
        .val_i (cnt_q),
        .dir_i (dir_sel),
        .tc_o  (tc)
    );

    // Purpose: count register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_nxt;
    end

    assign count = cnt_q;
endmodule

// File: rtl/updn_tc_counter_chk.sv
// Module: updn_tc_counter_chk
// Property checker for updn_tc_counter. It observes the ports only and is
// attached to the top module with the bind statement at the end of this file.
module updn_tc_counter_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             ld,
    input logic [WIDTH-1:0] ld_val,
    input logic             en,
    input logic             dir,
    input logic [WIDTH-1:0] count,
    input logic             tc
);
    // R1: a reset edge leaves the count at zero.
    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> count == '0);

    // R2: clear wins over every other control.
    a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == '0);

    // R3: load captures the data word.
    a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && ld) |=> count == $past(ld_val));

    // R4: up step, wrapping at all ones.
    a_r4_up_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !ld && en && !dir) |=> count == $past(count) + WIDTH'(1));

    // R5: down step, wrapping at zero.
    a_r5_down_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !ld && en && dir) |=> count == $past(count) - WIDTH'(1));

    // R6: hold when idle.
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !ld && !en) |=> $stable(count));

    // R7: in the up direction the flag marks exactly all ones.
    a_r7_tc_up: assert property (@(posedge clk) disable iff (!rst_n)
        !dir |-> (tc == (count == {WIDTH{1'b1}})));

    // R8: in the down direction the flag marks exactly zero.
    a_r8_tc_down: assert property (@(posedge clk) disable iff (!rst_n)
        dir |-> (tc == (count == '0)));
endmodule

bind updn_tc_counter updn_tc_counter_chk #(.WIDTH(WIDTH)) chk_i (.*);

// File: tb/updn_tc_counter_tb_top.sv
`timescale 1ns/1ps
module updn_tc_counter_tb_top;
    localparam int WIDTH = 4;
    localparam int NVAL  = 1 << WIDTH;
    localparam int MASK  = NVAL - 1;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             clr;
    logic             ld;
    logic [WIDTH-1:0] ld_val;
    logic             en;
    logic             dir;
    logic [WIDTH-1:0] count;
    logic             tc;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    updn_tc_counter #(.WIDTH(WIDTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .ld(ld), .ld_val(ld_val),
        .en(en), .dir(dir), .count(count), .tc(tc)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    // Drive the inputs at the falling edge, then wait for the rising edge.
    task automatic cyc(input bit c, input bit l, input int v, input bit e, input bit d);
        @(negedge clk);
        clr = c; ld = l; ld_val = WIDTH'(v); en = e; dir = d;
        @(posedge clk);
        #1;
    endtask

    function automatic int tc_model(input int v, input bit d);
        return d ? int'(v == 0) : int'(v == MASK);
    endfunction

    initial begin
        #(5.0 * 150000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        report();
    end

    initial begin
        int exp;
        rst_n = 1'b0; clr = 1'b0; ld = 1'b1; ld_val = '1; en = 1'b1; dir = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset", int'(count), 0);
        @(negedge clk);
        rst_n = 1'b1; ld = 1'b0; en = 1'b0;

        // Sweep every start value, both directions, enable high and low.
        for (int v = 0; v < NVAL; v++) begin
            for (int d = 0; d < 2; d++) begin
                for (int e = 0; e < 2; e++) begin
                    cyc(1'b0, 1'b1, v, ~e[0], d[0]);
                    chk("R3 load", int'(count), v);
                    @(negedge clk);
                    ld = 1'b0; en = e[0]; dir = d[0];
                    #1;
                    chk(d ? "R8 tc down" : "R7 tc up", int'(tc), tc_model(v, d[0]));
                    @(posedge clk);
                    #1;
                    if (e == 0)      exp = v;
                    else if (d == 0) exp = (v + 1) & MASK;
                    else             exp = (v + MASK) & MASK;
                    chk(e == 0 ? "R6 hold" : (d == 0 ? "R4 up" : "R5 down"),
                        int'(count), exp);
                end
            end
        end

        // Clear wins over load and enable.
        cyc(1'b0, 1'b1, 9, 1'b0, 1'b0);
        cyc(1'b1, 1'b1, 5, 1'b1, 1'b1);
        chk("R2 clear priority", int'(count), 0);

        // Load wins over enable.
        cyc(1'b0, 1'b1, 6, 1'b1, 1'b0);
        chk("R3 load over enable", int'(count), 6);

        // Timer-style run up through the wrap.
        cyc(1'b1, 1'b0, 0, 1'b0, 1'b0);
        exp = 0;
        for (int k = 0; k < NVAL + 4; k++) begin
            cyc(1'b0, 1'b0, 0, 1'b1, 1'b0);
            exp = (exp + 1) & MASK;
            chk("R4 up run", int'(count), exp);
            chk("R7 tc up run", int'(tc), tc_model(exp, 1'b0));
        end

        // Down run through the wrap.
        exp = int'(count);
        for (int k = 0; k < NVAL + 4; k++) begin
            cyc(1'b0, 1'b0, 0, 1'b1, 1'b1);
            exp = (exp + MASK) & MASK;
            chk("R5 down run", int'(count), exp);
            chk("R8 tc down run", int'(tc), tc_model(exp, 1'b1));
        end

        // The flag is the same with the enable low (checked before the edge).
        cyc(1'b0, 1'b1, 0, 1'b0, 1'b1);
        #1;
        chk("R8 tc with enable low", int'(tc), 1);
        @(negedge clk);
        dir = 1'b0;
        #1;
        chk("R7 tc at zero counting up", int'(tc), 0);

        report();
    end
endmodule